// File: doc/BRIEF.md
# Five-Bit Bidirectional GPIO Port

This block is a small general-purpose I/O port with five pins. Each pin has an output data latch and a direction latch. The data latch holds the value the pin drives. The direction latch decides whether the driver is enabled or left in high impedance. A register bus writes either latch. A read returns either the synchronized pin levels or the direction latch. Toward the pads the block gives a drive value and an output-enable for each pin.

Two pins behave in special ways. The top pin, bit 4, is open-drain: it only ever pulls low. Its synchronized input level is also brought out as a raw clock source for a timer. The lower four pins can each be marked analog through a mode input. An analog pin always reads as 0 on the data path, but its driver still follows the direction latch. The analog mask is held in a register that resets to all-analog. The port therefore reads its lower pins as 0 from reset until the first configuration is loaded.

Top module: `gpio5_port`

## Requirements
- R1: While reset is asserted, the direction latch reads 5'b11111, the data latch is cleared, and every bit of `pad_oe` is 0.
- R2: For bits 3..0, a direction bit of 0 sets `pad_oe` to 1 and `pad_out` to that bit's data latch value. A direction bit of 1 sets `pad_oe` to 0.
- R3: A read with `bus_addr`=0 returns the synchronized pin levels in bits 4..0, not the data latch contents.
- R4: A write with `bus_addr`=0 loads `bus_wdata[4:0]` into the data latch and leaves the direction latch unchanged.
- R5: A write with `bus_addr`=1 loads the direction latch. A read with `bus_addr`=1 returns the direction latch in bits 4..0. Bits 7..5 of `bus_rdata` read 0 at both addresses.
- R6: Bit 4 is open-drain. `pad_out[4]` is always 0, and `pad_oe[4]` is 1 only when both its direction bit and its data latch bit are 0.
- R7: `tmr_clk_raw` equals `pin_in[4]` delayed by two clock edges.
- R8: `ana_mode[i]`=1 marks bit i (i in 3..0) as analog. The mask takes effect one clock edge after it is applied. An analog bit reads 0 at `bus_addr`=0.
- R9: Analog mode has no effect on the drivers. An analog pin whose direction bit is 0 still drives its data latch value.
- R10: The analog mask resets to all ones. While reset is held, the lower four bits read 0 at `bus_addr`=0 whatever `ana_mode` is, while bit 4 still shows its pin.
- R11: A change on any pin appears in a data-address read after two clock edges and not after one.
- R12: A software read-modify-write (read address 0, change one bit, write it back) copies the pin levels of input pins into their data latch bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 1 | Register select: 0 = pin/data, 1 = direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| ana_mode | input | 4 | Analog select for bits 3..0, 1 = analog |
| pin_in | input | 5 | Pad input levels |
| pad_out | output | 5 | Pad drive values |
| pad_oe | output | 5 | Pad output enables, 1 = drive |
| tmr_clk_raw | output | 1 | Synchronized bit-4 input for a timer clock |

## Verification
Pin patterns are chosen to differ from the latch contents, so a data read can only pass if it returns pins and not the latch. Direction patterns mix outputs and inputs. This separates the push-pull lower bits from the open-drain top bit, and shows that a data write leaves the direction latch alone. Alternating analog masks, applied with some pins set as outputs, show that analog mode forces reads to 0 but leaves the drivers working. A read-modify-write with pins that differ from the latch shows input-pin levels being copied into the latch. Stepping a pin one edge at a time pins down the two-edge latency on both the read path and the timer output.

// File: rtl/gpio5_pkg.sv
package gpio5_pkg;
    localparam int PORT_W = 5;
    localparam int ANA_W  = 4;
    localparam int BUS_W  = 8;
    localparam int OD_BIT = 4;

    typedef enum logic {
        SEL_PIN = 1'b0,
        SEL_DIR = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/gpio5_sync.sv
module gpio5_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_s
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_in;
        s_d.stab = s_q.meta;
    end

    // Synchronizer flops carry no reset so pins propagate even while reset is held.
    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign pin_s = s_q.stab;
endmodule

// File: rtl/gpio5_regs.sv
module gpio5_regs
    import gpio5_pkg::*;
#(
    parameter int W  = 5,
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ana_mode,
    output logic [W-1:0]  lat,
    output logic [W-1:0]  dir,
    output logic [AW-1:0] ana
);
    typedef struct packed {
        logic [W-1:0]  lat;
        logic [W-1:0]  dir;
        logic [AW-1:0] ana;
    } regs_t;

    localparam regs_t RESET_VAL = '{lat: '0, dir: '1, ana: '1};

    regs_t r_d, r_q;
    logic  unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DW-1:W];

    always_comb begin
        r_d     = r_q;
        r_d.ana = ana_mode;
        if (wr) begin
            if (reg_sel_e'(sel) == SEL_DIR) begin
                r_d.dir = wdata[W-1:0];
            end else begin
                r_d.lat = wdata[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign lat = r_q.lat;
    assign dir = r_q.dir;
    assign ana = r_q.ana;
endmodule

// File: rtl/gpio5_drive.sv
module gpio5_drive #(
    parameter int W      = 5,
    parameter int OD_BIT = 4
) (
    input  logic [W-1:0] lat,
    input  logic [W-1:0] dir,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == OD_BIT) begin : g_od
            assign pad_out[i] = 1'b0;
            assign pad_oe[i]  = ~dir[i] & ~lat[i];
        end else begin : g_pp
            assign pad_out[i] = lat[i];
            assign pad_oe[i]  = ~dir[i];
        end
    end
endmodule

// File: rtl/gpio5_rdmux.sv
module gpio5_rdmux
    import gpio5_pkg::*;
#(
    parameter int W  = 5,
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          sel,
    input  logic [W-1:0]  pin_s,
    input  logic [W-1:0]  dir,
    input  logic [AW-1:0] ana,
    output logic [DW-1:0] rdata
);
    logic [W-1:0] pin_view;

    for (genvar i = 0; i < W; i++) begin : g_view
        if (i < AW) begin : g_ana
            assign pin_view[i] = pin_s[i] & ~ana[i];
        end else begin : g_dig
            assign pin_view[i] = pin_s[i];
        end
    end

    always_comb begin
        rdata = '0;
        if (reg_sel_e'(sel) == SEL_DIR) begin
            rdata[W-1:0] = dir;
        end else begin
            rdata[W-1:0] = pin_view;
        end
    end
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port
    import gpio5_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int AW     = ANA_W,
    parameter int DW     = BUS_W,
    parameter int OD     = OD_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [AW-1:0] ana_mode,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic          tmr_clk_raw
);
    logic [W-1:0]  pin_s;
    logic [W-1:0]  lat_w;
    logic [W-1:0]  dir_w;
    logic [AW-1:0] ana_w;

    gpio5_sync #(.W(W)) u_sync (
        .clk    (clk),
        .pin_in (pin_in),
        .pin_s  (pin_s)
    );

    gpio5_regs #(.W(W), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .sel      (bus_addr),
        .wdata    (bus_wdata),
        .ana_mode (ana_mode),
        .lat      (lat_w),
        .dir      (dir_w),
        .ana      (ana_w)
    );

    gpio5_drive #(.W(W), .OD_BIT(OD)) u_drive (
        .lat     (lat_w),
        .dir     (dir_w),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    gpio5_rdmux #(.W(W), .AW(AW), .DW(DW)) u_rdmux (
        .sel   (bus_addr),
        .pin_s (pin_s),
        .dir   (dir_w),
        .ana   (ana_w),
        .rdata (bus_rdata)
    );

    assign tmr_clk_raw = pin_s[OD];
endmodule

// File: rtl/gpio5_port_chk.sv
module gpio5_port_chk #(
    parameter int W  = 5,
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int OD = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [W-1:0]  pin_in,
    input logic [W-1:0]  pad_out,
    input logic [W-1:0]  pad_oe,
    input logic          tmr_clk_raw,
    input logic [W-1:0]  lat_w,
    input logic [W-1:0]  dir_w,
    input logic [AW-1:0] ana_w
);
    // R2
    dir_write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr) |=> (pad_oe[AW-1:0] == ~$past(bus_wdata[AW-1:0])));

    // R4
    data_write_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr) |=> (dir_w == $past(dir_w)));

    // R5
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:W] == '0);

    // R6
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[OD] |-> (pad_out[OD] == 1'b0 && lat_w[OD] == 1'b0 && dir_w[OD] == 1'b0));

    // R7
    tmr_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clk_raw == $past(pin_in[OD], 2));

    // R8
    analog_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr |-> ((bus_rdata[AW-1:0] & ana_w) == '0));
endmodule

bind gpio5_port gpio5_port_chk #(.W(W), .AW(AW), .DW(DW), .OD(OD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_in      (pin_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .tmr_clk_raw (tmr_clk_raw),
    .lat_w       (lat_w),
    .dir_w       (dir_w),
    .ana_w       (ana_w)
);

// File: tb/gpio5_port_bench.sv
module gpio5_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] ana_mode = '0;
    logic [4:0] pin_in = 5'h1F;
    logic [4:0] pad_out;
    logic [4:0] pad_oe;
    logic       tmr_clk_raw;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio5_port u_gpio5_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ana_mode    (ana_mode),
        .pin_in      (pin_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .tmr_clk_raw (tmr_clk_raw)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rd_reg(1'b0, v); check("R10 lower bits analog in reset", v, 8'h10);
        rd_reg(1'b1, v); check("R1 dir reset / R5 dir read", v, 8'h1F);
        check("R1 oe in reset", {3'b0, pad_oe}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_reg(1'b0, v); check("R3 pins after reset", v, 8'h1F);
    endtask

    task automatic t_drive;
        logic [7:0] v;
        wr_reg(1'b0, 8'hEA);
        wr_reg(1'b1, 8'h10);
        check("R2 oe lower outputs", {3'b0, pad_oe}, 8'h0F);
        check("R2 drive value", {4'b0, pad_out[3:0]}, 8'h0A);
        rd_reg(1'b0, v); check("R3 read pins not latch", v, 8'h1F);
        rd_reg(1'b1, v); check("R5 dir read upper zero", v, 8'h10);
        wr_reg(1'b1, 8'h1A);
        check("R2 mixed dir oe", {3'b0, pad_oe}, 8'h05);
    endtask

    task automatic t_data_write;
        logic [7:0] v;
        wr_reg(1'b1, 8'h10);
        wr_reg(1'b0, 8'h05);
        rd_reg(1'b1, v); check("R4 dir unchanged by data write", v, 8'h10);
        check("R4 latch loaded", {4'b0, pad_out[3:0]}, 8'h05);
    endtask

    task automatic t_open_drain;
        wr_reg(1'b1, 8'h00);
        wr_reg(1'b0, 8'h00);
        check("R6 od pulls low oe", {7'b0, pad_oe[4]}, 8'h01);
        check("R6 od value", {7'b0, pad_out[4]}, 8'h00);
        wr_reg(1'b0, 8'h10);
        check("R6 od released latch 1", {7'b0, pad_oe[4]}, 8'h00);
        check("R6 od value latch 1", {7'b0, pad_out[4]}, 8'h00);
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h10);
        check("R6 od released as input", {7'b0, pad_oe[4]}, 8'h00);
    endtask

    task automatic t_latency;
        logic [7:0] v;
        @(negedge clk); pin_in = 5'h0E;
        @(negedge clk);
        check("R7 tmr after one edge", {7'b0, tmr_clk_raw}, 8'h01);
        rd_reg(1'b0, v); check("R11 read after one edge", v, 8'h1F);
        @(negedge clk);
        check("R7 tmr after two edges", {7'b0, tmr_clk_raw}, 8'h00);
        rd_reg(1'b0, v); check("R11 read after two edges", v, 8'h0E);
        pin_in = 5'h1F;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_analog;
        logic [7:0] v;
        wr_reg(1'b0, 8'h0A);
        wr_reg(1'b1, 8'h1A);
        @(negedge clk); ana_mode = 4'b0101;
        @(negedge clk);
        rd_reg(1'b0, v); check("R8 analog bits read 0", v, 8'h1A);
        check("R9 analog pins still driven oe", {3'b0, pad_oe}, 8'h05);
        check("R9 analog drive value", {4'b0, pad_out[3:0]}, 8'h0A);
        ana_mode = 4'b1010;
        @(negedge clk);
        rd_reg(1'b0, v); check("R8 alternate mask", v, 8'h15);
        ana_mode = 4'b0000;
        @(negedge clk);
    endtask

    task automatic t_rmw;
        logic [7:0] v;
        wr_reg(1'b1, 8'h1E);
        wr_reg(1'b0, 8'h00);
        @(negedge clk); pin_in = 5'h06;
        repeat (2) @(negedge clk);
        rd_reg(1'b0, v);
        wr_reg(1'b0, v | 8'h01);
        wr_reg(1'b1, 8'h00);
        check("R12 rmw copies pin levels", {4'b0, pad_out[3:0]}, 8'h07);
    endtask

    initial begin
        t_reset();
        t_drive();
        t_data_write();
        t_open_drain();
        t_latency();
        t_analog();
        t_rmw();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule